// File: doc/BRIEF.md
# Ingress Default-VLAN Classifier

This block sits at the receive side of a five-port switch and decides, for every incoming frame descriptor, which VLAN the frame belongs to, whether the port's default VLAN tag must be added, and whether the frame is thrown away by the VLAN membership check. A descriptor carries the ingress port number, a flag telling whether the frame already has a tag, and the VLAN ID of that tag. The classified VLAN ID is offered combinationally on `lk_vid` to a neighbouring VLAN table. That table answers in the same cycle with a hit flag and the member-port mask of the entry.

Per-port behaviour is set through a small write-only configuration port. Each port has a 2-bit input mode, an insertion-enable bit, a 12-bit default VLAN ID, and a verify bit and a discard bit. A default tag is added only when the port's mode is "tag always" and its insertion-enable bit is also set. Without that bit the frame keeps its own tag, or falls into VLAN 0 when it has none. With both verify and discard set on a port, a frame whose classified VLAN misses the table, or whose port is not a member, is marked for drop.

A two-state control sequence paces the result. The states are `ST_IDLE` (no result presented) and `ST_EMIT` (a result is presented on the outputs). The transitions are:
- `ST_IDLE` to `ST_EMIT` on a descriptor strobe.
- `ST_EMIT` to `ST_EMIT` on another strobe (back-to-back descriptors).
- `ST_EMIT` to `ST_IDLE` when there is no strobe.

The result fields are registered and hold their value between descriptors.

Top module: `ingress_pvid_filter`

## Requirements
- R1: After reset all configuration fields are zero and `out_valid` is low; an untagged frame then gets VLAN 0, no insertion and no drop.
- R2: `out_valid` is high in exactly the cycle after each cycle with `desc_valid` high, including back-to-back descriptors; the result fields hold their value while no descriptor arrives.
- R3: Mode word at byte address 0x000 holds port p's mode in bits [2p+1:2p], insertion-enable word at 0x004 holds port p's enable in bit p, and port p's default VLAN is in bits [11:0] of the word at 0x200+4p. When the mode is 2 and the enable is set, `out_insert` is 1 and `out_vid` is the default VLAN, for tagged and untagged frames alike.
- R4: With mode 2 but the enable clear, no insertion happens and the frame is classified as without insertion.
- R5: Mode values 0, 1 and 3 never cause insertion, whatever the enable bit.
- R6: Without insertion a tagged frame keeps its own VLAN ID and an untagged frame is classified into VLAN 0.
- R7: `lk_vid` shows, in the same cycle as the descriptor, the VLAN ID that the registered result will carry.
- R8: The filter word at 0x008 holds port p's verify in bit p and discard in bit 16+p. With both set, the frame is dropped when `lk_hit` is 0 or bit p of `lk_members` is 0.
- R9: A port with only verify, or only discard, set never drops a frame.
- R10: A descriptor whose port number is 5 or above is dropped, never gets a tag inserted, and keeps its own VLAN ID (0 if untagged).
- R11: A configuration write in the same cycle as a descriptor takes effect from the next descriptor on. Writes to unmapped addresses change nothing.
- R12: The configuration of one port has no effect on frames of another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| desc_valid | input | 1 | Descriptor strobe |
| desc_port | input | 3 | Ingress port number |
| desc_tagged | input | 1 | Frame already carries a VLAN tag |
| desc_vid | input | 12 | VLAN ID of the frame's tag |
| lk_vid | output | 12 | Classified VLAN ID offered to the VLAN table |
| lk_hit | input | 1 | VLAN table holds `lk_vid` |
| lk_members | input | 5 | Member-port mask of the matching entry |
| out_valid | output | 1 | Result presented |
| out_insert | output | 1 | Default tag to be inserted |
| out_vid | output | 12 | Final VLAN ID |
| out_drop | output | 1 | Frame to be dropped |

## Verification
Descriptors are sent as untagged and tagged frames under every input mode value, with the enable bit both set and clear. This separates the mode test from the enable test and shows whether insertion also overrides an existing tag. Filtering is tried with a table hit and a member port, with a hit on a non-member port, and with a miss. It is also tried with verify only and with discard only set, which shows whether both bits are required. Port numbers beyond the last port, writes that coincide with a descriptor, writes to unmapped addresses, and back-to-back against gapped descriptors complete the set.

// File: rtl/ingress_cls_pkg.sv
package ingress_cls_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cls_state_e;

    localparam logic [1:0] MODE_TAG_ALWAYS = 2'd2;

    localparam int ADDR_MODE      = 'h000;
    localparam int ADDR_INSEN     = 'h004;
    localparam int ADDR_FILT      = 'h008;
    localparam int ADDR_PVID_BASE = 'h200;
    localparam int ADDR_STRIDE    = 4;
    localparam int DISCARD_SHIFT  = 16;

endpackage

// File: rtl/ing_cfg_regs.sv
module ing_cfg_regs
    import ingress_cls_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int VID_W  = 12,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [2*NPORT-1:0]       mode_o,
    output logic [NPORT-1:0]         insen_o,
    output logic [NPORT-1:0]         verify_o,
    output logic [NPORT-1:0]         discard_o,
    output logic [NPORT*VID_W-1:0]   pvid_o
);

    logic [2*NPORT-1:0] mode_q;
    logic [NPORT-1:0]   insen_q;
    logic [NPORT-1:0]   verify_q;
    logic [NPORT-1:0]   discard_q;
    logic [VID_W-1:0]   pvid_q [NPORT];
    logic [NPORT-1:0]   pvid_hit;

    wire hit_mode  = cfg_we && (cfg_addr == ADDR_W'(ADDR_MODE));
    wire hit_insen = cfg_we && (cfg_addr == ADDR_W'(ADDR_INSEN));
    wire hit_filt  = cfg_we && (cfg_addr == ADDR_W'(ADDR_FILT));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign pvid_hit[p] = cfg_we &&
            (cfg_addr == ADDR_W'(ADDR_PVID_BASE + ADDR_STRIDE * p));
        assign pvid_o[p*VID_W +: VID_W] = pvid_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            insen_q   <= '0;
            verify_q  <= '0;
            discard_q <= '0;
            for (int p = 0; p < NPORT; p++) pvid_q[p] <= '0;
        end else begin
            if (hit_mode)  mode_q  <= cfg_wdata[2*NPORT-1:0];
            if (hit_insen) insen_q <= cfg_wdata[NPORT-1:0];
            if (hit_filt) begin
                verify_q  <= cfg_wdata[NPORT-1:0];
                discard_q <= cfg_wdata[DISCARD_SHIFT +: NPORT];
            end
            for (int p = 0; p < NPORT; p++)
                if (pvid_hit[p]) pvid_q[p] <= cfg_wdata[VID_W-1:0];
        end
    end

    assign mode_o    = mode_q;
    assign insen_o   = insen_q;
    assign verify_o  = verify_q;
    assign discard_o = discard_q;

endmodule

// File: rtl/ing_classify.sv
module ing_classify
    import ingress_cls_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int VID_W  = 12,
    parameter int PORT_W = 3
) (
    input  logic [PORT_W-1:0]        port_i,
    input  logic                     tagged_i,
    input  logic [VID_W-1:0]         vid_i,
    input  logic [2*NPORT-1:0]       mode_i,
    input  logic [NPORT-1:0]         insen_i,
    input  logic [NPORT-1:0]         verify_i,
    input  logic [NPORT-1:0]         discard_i,
    input  logic [NPORT*VID_W-1:0]   pvid_i,
    input  logic                     lk_hit_i,
    input  logic [NPORT-1:0]         lk_members_i,
    output logic [VID_W-1:0]         vid_o,
    output logic                     insert_o,
    output logic                     drop_o
);

    logic port_ok;
    int   idx;
    logic filt_on;
    logic violation;

    always_comb begin
        port_ok   = int'(port_i) < NPORT;
        idx       = port_ok ? int'(port_i) : 0;
        insert_o  = port_ok && insen_i[idx] &&
                    (mode_i[2*idx +: 2] == MODE_TAG_ALWAYS);
        if (insert_o)      vid_o = pvid_i[idx*VID_W +: VID_W];
        else if (tagged_i) vid_o = vid_i;
        else               vid_o = '0;
        filt_on   = verify_i[idx] && discard_i[idx];
        violation = !lk_hit_i || !lk_members_i[idx];
        drop_o    = !port_ok || (filt_on && violation);
    end

endmodule

// File: rtl/ingress_pvid_filter.sv
module ingress_pvid_filter
    import ingress_cls_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int VID_W  = 12,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT + 1) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               desc_valid,
    input  logic [PORT_W-1:0]  desc_port,
    input  logic               desc_tagged,
    input  logic [VID_W-1:0]   desc_vid,
    output logic [VID_W-1:0]   lk_vid,
    input  logic               lk_hit,
    input  logic [NPORT-1:0]   lk_members,
    output logic               out_valid,
    output logic               out_insert,
    output logic [VID_W-1:0]   out_vid,
    output logic               out_drop
);

    logic [2*NPORT-1:0]     mode_w;
    logic [NPORT-1:0]       insen_w;
    logic [NPORT-1:0]       verify_w;
    logic [NPORT-1:0]       discard_w;
    logic [NPORT*VID_W-1:0] pvid_w;
    logic                   cls_insert;
    logic                   cls_drop;
    cls_state_e             state_q;
    cls_state_e             state_d;

    ing_cfg_regs #(
        .NPORT(NPORT), .VID_W(VID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_o    (mode_w),
        .insen_o   (insen_w),
        .verify_o  (verify_w),
        .discard_o (discard_w),
        .pvid_o    (pvid_w)
    );

    ing_classify #(
        .NPORT(NPORT), .VID_W(VID_W), .PORT_W(PORT_W)
    ) u_cls (
        .port_i       (desc_port),
        .tagged_i     (desc_tagged),
        .vid_i        (desc_vid),
        .mode_i       (mode_w),
        .insen_i      (insen_w),
        .verify_i     (verify_w),
        .discard_i    (discard_w),
        .pvid_i       (pvid_w),
        .lk_hit_i     (lk_hit),
        .lk_members_i (lk_members),
        .vid_o        (lk_vid),
        .insert_o     (cls_insert),
        .drop_o       (cls_drop)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (desc_valid) state_d = ST_EMIT;
            ST_EMIT: if (!desc_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_insert <= 1'b0;
            out_vid    <= '0;
            out_drop   <= 1'b0;
        end else if (desc_valid) begin
            out_insert <= cls_insert;
            out_vid    <= lk_vid;
            out_drop   <= cls_drop;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/ingress_pvid_chk.sv
module ingress_pvid_chk #(
    parameter int NPORT  = 5,
    parameter int VID_W  = 12,
    parameter int PORT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic [PORT_W-1:0] desc_port,
    input logic              desc_tagged,
    input logic [VID_W-1:0]  desc_vid,
    input logic [NPORT-1:0]  insen,
    input logic [NPORT-1:0]  verify,
    input logic [NPORT-1:0]  discard,
    input logic              out_valid,
    input logic              out_insert,
    input logic [VID_W-1:0]  out_vid,
    input logic              out_drop
);

    logic in_range;
    int   pidx;
    logic en_here;
    logic filt_here;

    always_comb begin
        in_range  = int'(desc_port) < NPORT;
        pidx      = in_range ? int'(desc_port) : 0;
        en_here   = in_range && insen[pidx];
        filt_here = verify[pidx] && discard[pidx];
    end

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |=> out_valid);

    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> !out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> ($stable(out_vid) && $stable(out_drop) && $stable(out_insert)));

    a_r4_no_insert_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !en_here) |=> !out_insert);

    a_r6_own_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_tagged && !en_here) |=> (out_vid == $past(desc_vid)));

    a_r9_no_drop_unfiltered: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && in_range && !filt_here) |=> !out_drop);

    a_r10_bad_port_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !in_range) |=> (out_drop && !out_insert));

endmodule

bind ingress_pvid_filter ingress_pvid_chk #(
    .NPORT(NPORT), .VID_W(VID_W), .PORT_W(PORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_port   (desc_port),
    .desc_tagged (desc_tagged),
    .desc_vid    (desc_vid),
    .insen       (insen_w),
    .verify      (verify_w),
    .discard     (discard_w),
    .out_valid   (out_valid),
    .out_insert  (out_insert),
    .out_vid     (out_vid),
    .out_drop    (out_drop)
);

// File: tb/tb_ingress_pvid_filter.sv
module tb_ingress_pvid_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        desc_valid = 1'b0;
    logic [2:0]  desc_port = '0;
    logic        desc_tagged = 1'b0;
    logic [11:0] desc_vid = '0;
    logic [11:0] lk_vid;
    logic        lk_hit;
    logic [4:0]  lk_members;
    logic        out_valid;
    logic        out_insert;
    logic [11:0] out_vid;
    logic        out_drop;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R1";

    // bench model state
    int m_mode [NP];
    bit m_en   [NP];
    bit m_ver  [NP];
    bit m_disc [NP];
    int m_pvid [NP];
    bit e_valid = 0;
    bit e_ins = 0;
    int e_vid = 0;
    bit e_drop = 0;

    // VLAN table held by the bench
    int tbl_vid [3] = '{100, 5, 'h123};
    int tbl_mem [3] = '{5'b00101, 5'b00010, 5'b11111};

    ingress_pvid_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .desc_valid(desc_valid), .desc_port(desc_port),
        .desc_tagged(desc_tagged), .desc_vid(desc_vid), .lk_vid(lk_vid),
        .lk_hit(lk_hit), .lk_members(lk_members), .out_valid(out_valid),
        .out_insert(out_insert), .out_vid(out_vid), .out_drop(out_drop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tbl_find(input int v);
        for (int i = 0; i < 3; i++) if (tbl_vid[i] == v) return i;
        return -1;
    endfunction

    always_comb begin
        int k;
        k = tbl_find(int'(lk_vid));
        lk_hit     = (k >= 0);
        lk_members = (k >= 0) ? 5'(tbl_mem[k]) : 5'b0;
    end

    function automatic void model_cls(input int p, input bit t, input int v,
                                      output bit ins, output int ov, output bit drp);
        int k;
        bit member;
        if (p >= NP) begin
            ins = 0;
            ov  = t ? v : 0;
            drp = 1;
            return;
        end
        ins = (m_mode[p] == 2) && m_en[p];
        ov  = ins ? m_pvid[p] : (t ? v : 0);
        k = tbl_find(ov);
        member = (k >= 0) && tbl_mem[k][p];
        drp = m_ver[p] && m_disc[p] && !member;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_ins = 0; e_vid = 0; e_drop = 0;
            for (int p = 0; p < NP; p++) begin
                m_mode[p] = 0; m_en[p] = 0; m_ver[p] = 0; m_disc[p] = 0; m_pvid[p] = 0;
            end
        end else begin
            e_valid = desc_valid;
            if (desc_valid)
                model_cls(int'(desc_port), desc_tagged, int'(desc_vid), e_ins, e_vid, e_drop);
            if (cfg_we) begin
                if (cfg_addr == 12'h000)
                    for (int p = 0; p < NP; p++) m_mode[p] = int'(cfg_wdata[2*p +: 2]);
                else if (cfg_addr == 12'h004)
                    for (int p = 0; p < NP; p++) m_en[p] = cfg_wdata[p];
                else if (cfg_addr == 12'h008)
                    for (int p = 0; p < NP; p++) begin
                        m_ver[p]  = cfg_wdata[p];
                        m_disc[p] = cfg_wdata[16 + p];
                    end
                else
                    for (int p = 0; p < NP; p++)
                        if (cfg_addr == 12'(12'h200 + 4 * p)) m_pvid[p] = int'(cfg_wdata[11:0]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(out_valid == e_valid, cur_req, "out_valid", int'(out_valid), int'(e_valid));
            check(out_insert == e_ins, cur_req, "out_insert", int'(out_insert), int'(e_ins));
            check(int'(out_vid) == e_vid, cur_req, "out_vid", int'(out_vid), e_vid);
            check(out_drop == e_drop, cur_req, "out_drop", int'(out_drop), int'(e_drop));
        end
    end

    task automatic cyc(input bit we, input int addr, input int data,
                       input bit dv, input int port, input bit tag, input int vid);
        bit ins, drp;
        int ov;
        @(negedge clk);
        cfg_we = we; cfg_addr = 12'(addr); cfg_wdata = 32'(data);
        desc_valid = dv; desc_port = 3'(port); desc_tagged = tag; desc_vid = 12'(vid);
        #1;
        if (dv) begin
            model_cls(port, tag, vid, ins, ov, drp);
            check(int'(lk_vid) == ov, "R7", "lk_vid", int'(lk_vid), ov);
        end
    endtask

    task automatic wr(input int addr, input int data);
        cyc(1, addr, data, 0, 0, 0, 0);
    endtask

    task automatic send(input int port, input bit tag, input int vid);
        cyc(0, 0, 0, 1, port, tag, vid);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_vid == 12'd0 && !out_drop && !out_insert, "R1", "fields after reset",
              int'(out_vid), 0);
        started = 1;
        idle(1);

        cur_req = "R1";
        send(0, 0, 0);
        idle(1);

        cur_req = "R6";
        send(1, 1, 100); send(2, 1, 77); send(4, 0, 55);
        idle(1);

        cur_req = "R4";
        wr('h000, 'h2AA);
        send(0, 0, 9); send(0, 1, 100);
        idle(1);

        cur_req = "R3";
        wr('h200, 5); wr('h204, 'h123); wr('h208, 'hFFF); wr('h004, 'b00011);
        send(0, 0, 0); send(0, 1, 100); send(1, 1, 33); send(2, 0, 0);
        idle(1);

        cur_req = "R5";
        wr('h000, 'h28D); wr('h004, 'h1F); wr('h20C, 100);
        send(0, 0, 0); send(1, 1, 42); send(2, 0, 0); send(3, 0, 0);
        idle(1);

        cur_req = "R8";
        wr('h008, 'h000F000F);
        send(0, 1, 100); send(1, 1, 100); send(2, 1, 100);
        send(0, 1, 200); send(3, 0, 0); send(1, 1, 5);
        idle(1);

        cur_req = "R9";
        wr('h008, 'h00100008);
        send(3, 1, 999); send(4, 1, 999);
        idle(1);

        cur_req = "R10";
        send(5, 1, 100); send(7, 0, 0); send(6, 1, 4095);
        idle(1);

        cur_req = "R11";
        cyc(1, 'h20C, 5, 1, 3, 0, 0);
        send(3, 0, 0);
        wr('h00C, -1); wr('h214, 'hABC); wr('h201, 'h777);
        send(3, 0, 0); send(0, 1, 7);
        idle(1);

        cur_req = "R12";
        wr('h210, 'h321);
        send(3, 0, 0); send(4, 0, 0); send(0, 0, 0);
        idle(1);

        cur_req = "R2";
        send(4, 1, 1); idle(2); send(3, 1, 2); send(2, 1, 3);
        idle(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule